// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block sits at the front of a fetch stage shared by several hardware threads. In every cycle it decides which threads may fetch and how many instructions each may request. The fetch width can go to a single thread, or it can be split evenly between two different threads.

A policy input sets the ranking used to pick the threads:
- plain rotation;
- fewest unresolved branches in the front end;
- fewest outstanding data-cache misses;
- fewest instructions held between decode and the instruction queues;
- a penalty for threads whose instructions sit nearest the head of an issue queue.

Threads that are inactive or stalled are never picked. When the ranking gives equal scores, a rotating pointer settles the tie, so no eligible thread is passed over forever. The choice is registered: the grant seen after a clock edge reflects only the inputs sampled at that edge.

Top module: `fts_sel`

## Requirements
- R1: While reset is high, and on the first edge after it, both slots are invalid with thread ID 0 and quota 0. Reset also returns the rotation pointer to thread 0.
- R2: A thread is granted only if its active bit is 1 and its stall bit is 0. When no thread is eligible, both slots are invalid with quota 0. When at least one thread is eligible, slot 0 is valid.
- R3: When split is 0 (one-by-eight), slot 0 carries the winner with quota FETCH_W (8), and slot 1 is invalid with quota 0.
- R4: When split is 1 (two-by-four), slot 0 and slot 1 carry two distinct threads with quota FETCH_W/2 (4) each. If only one thread is eligible, slot 1 is invalid with quota 0.
- R5: Policy code 0 is rotation: every eligible thread scores equally, so threads are served in cyclic order starting at the pointer. Codes 5 to 7 behave as code 0.
- R6: Policy code 1 favours the lowest branch count.
- R7: Policy code 2 favours the lowest miss count.
- R8: Policy code 3 favours the lowest instruction-occupancy count.
- R9: Policy code 4 ranks threads with the near-head flag set below all threads without it.
- R10: Equal scores are resolved in favour of the thread reached first when counting upward, cyclically, from the pointer. After each grant the pointer moves to one past the last granted thread. That thread is the one in slot 1 if slot 1 is valid, otherwise the one in slot 0. The pointer holds when nothing is granted.
- R11: The outputs change only at a clock edge. They reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 3 | Ranking policy code |
| split | input | 1 | 0: one thread gets the full width; 1: two threads get half each |
| thr_active | input | NTHR | Per-thread active flag |
| thr_stall | input | NTHR | Per-thread stall flag |
| br_cnt | input | NTHR*CNT_W | Per-thread unresolved branch counts, thread 0 in the low bits |
| miss_cnt | input | NTHR*CNT_W | Per-thread outstanding miss counts |
| inst_cnt | input | NTHR*CNT_W | Per-thread front-end instruction occupancy |
| near_head | input | NTHR | Per-thread flag: instructions nearest an issue queue head |
| slot0_vld | output | 1 | Slot 0 grant valid |
| slot0_tid | output | log2(NTHR) | Slot 0 thread ID |
| slot0_quota | output | log2(FETCH_W+1) | Slot 0 instruction quota |
| slot1_vld | output | 1 | Slot 1 grant valid |
| slot1_tid | output | log2(NTHR) | Slot 1 thread ID |
| slot1_quota | output | log2(FETCH_W+1) | Slot 1 instruction quota |

## Verification
The rotating pointer cannot be seen at the ports. Yet every tie, and every rotation grant, depends on it.

The stimulus reaches each pointer position by fixing the sequence of grants from reset onward. Vectors are ordered so that a tie-break case arrives with a known pointer that is not zero. One vector has no eligible thread, to show that the pointer holds. The next rotation vector then reveals where the pointer stands.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    POL_ROTATE = 3'd0,
    POL_BRANCH = 3'd1,
    POL_MISS   = 3'd2,
    POL_OCCUPY = 3'd3,
    POL_QHEAD  = 3'd4
  } policy_e;

  function automatic int tid_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fts_key.sv
module fts_key #(
  parameter int NTHR  = 4,
  parameter int CNT_W = 6
) (
  input  logic [2:0]            policy,
  input  logic [NTHR-1:0]       thr_active,
  input  logic [NTHR-1:0]       thr_stall,
  input  logic [NTHR*CNT_W-1:0] br_cnt,
  input  logic [NTHR*CNT_W-1:0] miss_cnt,
  input  logic [NTHR*CNT_W-1:0] inst_cnt,
  input  logic [NTHR-1:0]       near_head,
  output logic [NTHR*CNT_W-1:0] keys,
  output logic [NTHR-1:0]       elig
);
  import fts_pkg::*;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [CNT_W-1:0] key_t;
    always_comb begin
      case (policy)
        POL_BRANCH: key_t = br_cnt[t*CNT_W +: CNT_W];
        POL_MISS:   key_t = miss_cnt[t*CNT_W +: CNT_W];
        POL_OCCUPY: key_t = inst_cnt[t*CNT_W +: CNT_W];
        POL_QHEAD:  key_t = {{(CNT_W-1){1'b0}}, near_head[t]};
        default:    key_t = '0;
      endcase
    end
    assign keys[t*CNT_W +: CNT_W] = key_t;
    assign elig[t] = thr_active[t] & ~thr_stall[t];
  end
endmodule

// File: rtl/fts_pick.sv
module fts_pick #(
  parameter int NTHR  = 4,
  parameter int CNT_W = 6,
  localparam int TID_W = fts_pkg::tid_bits(NTHR)
) (
  input  logic [NTHR*CNT_W-1:0] keys,
  input  logic [NTHR-1:0]       elig,
  input  logic [TID_W-1:0]      ptr,
  output logic                  found,
  output logic [TID_W-1:0]      tid
);
  logic [CNT_W-1:0] best_key;
  logic [TID_W-1:0] best_dist;
  logic [CNT_W-1:0] key_i;
  logic [TID_W-1:0] dist_i;

  always_comb begin
    found     = 1'b0;
    tid       = '0;
    best_key  = '0;
    best_dist = '0;
    key_i     = '0;
    dist_i    = '0;
    for (int i = 0; i < NTHR; i++) begin
      key_i  = keys[i*CNT_W +: CNT_W];
      dist_i = TID_W'((i + NTHR - int'(ptr)) % NTHR);
      if (elig[i] && (!found || (key_i < best_key) ||
                      ((key_i == best_key) && (dist_i < best_dist)))) begin
        found     = 1'b1;
        tid       = TID_W'(i);
        best_key  = key_i;
        best_dist = dist_i;
      end
    end
  end
endmodule

// File: rtl/fts_sel.sv
module fts_sel #(
  parameter int NTHR    = 4,
  parameter int CNT_W   = 6,
  parameter int FETCH_W = 8,
  localparam int TID_W  = fts_pkg::tid_bits(NTHR),
  localparam int QW     = $clog2(FETCH_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            policy,
  input  logic                  split,
  input  logic [NTHR-1:0]       thr_active,
  input  logic [NTHR-1:0]       thr_stall,
  input  logic [NTHR*CNT_W-1:0] br_cnt,
  input  logic [NTHR*CNT_W-1:0] miss_cnt,
  input  logic [NTHR*CNT_W-1:0] inst_cnt,
  input  logic [NTHR-1:0]       near_head,
  output logic                  slot0_vld,
  output logic [TID_W-1:0]      slot0_tid,
  output logic [QW-1:0]         slot0_quota,
  output logic                  slot1_vld,
  output logic [TID_W-1:0]      slot1_tid,
  output logic [QW-1:0]         slot1_quota
);
  localparam logic [QW-1:0] Q_FULL = QW'(FETCH_W);
  localparam logic [QW-1:0] Q_HALF = QW'(FETCH_W / 2);

  logic [NTHR*CNT_W-1:0] keys;
  logic [NTHR-1:0]       elig, elig1;
  logic [TID_W-1:0]      ptr_q;
  logic                  f0, f1;
  logic [TID_W-1:0]      w0, w1;

  fts_key #(.NTHR(NTHR), .CNT_W(CNT_W)) u_key (
    .policy(policy), .thr_active(thr_active), .thr_stall(thr_stall),
    .br_cnt(br_cnt), .miss_cnt(miss_cnt), .inst_cnt(inst_cnt),
    .near_head(near_head), .keys(keys), .elig(elig)
  );

  fts_pick #(.NTHR(NTHR), .CNT_W(CNT_W)) u_pick0 (
    .keys(keys), .elig(elig), .ptr(ptr_q), .found(f0), .tid(w0)
  );

  assign elig1 = elig & ~(NTHR'(1) << w0);

  fts_pick #(.NTHR(NTHR), .CNT_W(CNT_W)) u_pick1 (
    .keys(keys), .elig(elig1), .ptr(ptr_q), .found(f1), .tid(w1)
  );

  function automatic logic [TID_W-1:0] next_tid(input logic [TID_W-1:0] t);
    return (int'(t) == NTHR - 1) ? '0 : t + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      slot0_vld   <= 1'b0;
      slot0_tid   <= '0;
      slot0_quota <= '0;
      slot1_vld   <= 1'b0;
      slot1_tid   <= '0;
      slot1_quota <= '0;
      ptr_q       <= '0;
    end else begin
      slot0_vld   <= f0;
      slot0_tid   <= f0 ? w0 : '0;
      slot0_quota <= f0 ? (split ? Q_HALF : Q_FULL) : '0;
      slot1_vld   <= split & f1;
      slot1_tid   <= (split & f1) ? w1 : '0;
      slot1_quota <= (split & f1) ? Q_HALF : '0;
      if (split & f1)
        ptr_q <= next_tid(w1);
      else if (f0)
        ptr_q <= next_tid(w0);
    end
  end
endmodule

// File: rtl/fts_chk.sv
module fts_chk #(
  parameter int NTHR    = 4,
  parameter int FETCH_W = 8,
  localparam int TID_W  = fts_pkg::tid_bits(NTHR),
  localparam int QW     = $clog2(FETCH_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             split,
  input logic [NTHR-1:0]  thr_active,
  input logic [NTHR-1:0]  thr_stall,
  input logic             slot0_vld,
  input logic [TID_W-1:0] slot0_tid,
  input logic [QW-1:0]    slot0_quota,
  input logic             slot1_vld,
  input logic [TID_W-1:0] slot1_tid,
  input logic [QW-1:0]    slot1_quota
);
  logic            past_ok, past_rst;
  logic [NTHR-1:0] elig_q;
  logic            split_q;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (rst) begin
      past_ok <= 1'b0;
      elig_q  <= '0;
      split_q <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      elig_q  <= thr_active & ~thr_stall;
      split_q <= split;
    end
  end

  always_ff @(posedge clk) begin
    if (past_rst === 1'b1)
      p_reset_zero_r1: assert (!slot0_vld && !slot1_vld && slot0_quota == '0 && slot1_quota == '0);
  end

  p_elig_slot0_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    slot0_vld |-> elig_q[slot0_tid]);
  p_elig_slot1_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    slot1_vld |-> elig_q[slot1_tid]);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (elig_q == '0) |-> (!slot0_vld && !slot1_vld));
  p_busy_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (elig_q != '0) |-> slot0_vld);
  p_solo_r3: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (!split_q && slot0_vld) |-> (!slot1_vld && slot0_quota == QW'(FETCH_W)));
  p_pair_r4: assert property (@(posedge clk) disable iff (rst || !past_ok)
    slot1_vld |-> (slot0_vld && slot0_tid != slot1_tid &&
                   slot0_quota == QW'(FETCH_W/2) && slot1_quota == QW'(FETCH_W/2)));
  p_pair_full_r4: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (split_q && $countones(elig_q) >= 2) |-> slot1_vld);
endmodule

bind fts_sel fts_chk #(.NTHR(NTHR), .FETCH_W(FETCH_W)) u_chk (
  .clk(clk), .rst(rst), .split(split), .thr_active(thr_active),
  .thr_stall(thr_stall), .slot0_vld(slot0_vld), .slot0_tid(slot0_tid),
  .slot0_quota(slot0_quota), .slot1_vld(slot1_vld), .slot1_tid(slot1_tid),
  .slot1_quota(slot1_quota)
);

// File: tb/fts_sel_tb_top.sv
`timescale 1ns/1ps
module fts_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  policy;
  logic        split;
  logic [3:0]  thr_active, thr_stall, near_head;
  logic [23:0] br_cnt, miss_cnt, inst_cnt;
  logic        slot0_vld, slot1_vld;
  logic [1:0]  slot0_tid, slot1_tid;
  logic [3:0]  slot0_quota, slot1_quota;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fts_sel dut_i (
    .clk(clk), .rst(rst), .policy(policy), .split(split),
    .thr_active(thr_active), .thr_stall(thr_stall), .br_cnt(br_cnt),
    .miss_cnt(miss_cnt), .inst_cnt(inst_cnt), .near_head(near_head),
    .slot0_vld(slot0_vld), .slot0_tid(slot0_tid), .slot0_quota(slot0_quota),
    .slot1_vld(slot1_vld), .slot1_tid(slot1_tid), .slot1_quota(slot1_quota)
  );

  typedef struct packed {
    logic [2:0]  pol;
    logic        spl;
    logic [3:0]  act;
    logic [3:0]  stl;
    logic [23:0] br;
    logic [23:0] ms;
    logic [23:0] ic;
    logic [3:0]  hd;
    logic        ev0;
    logic [1:0]  et0;
    logic [3:0]  eq0;
    logic        ev1;
    logic [1:0]  et1;
    logic [3:0]  eq1;
  } vec_t;

  localparam int NV = 15;
  localparam logic [23:0] Z = 24'd0;

  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 4'hF, 4'h0, Z, Z, Z, 4'h0, 1'b1, 2'd0, 4'd8, 1'b0, 2'd0, 4'd0},
    '{3'd0, 1'b0, 4'hF, 4'h0, Z, Z, Z, 4'h0, 1'b1, 2'd1, 4'd8, 1'b0, 2'd0, 4'd0},
    '{3'd0, 1'b1, 4'hF, 4'h0, Z, Z, Z, 4'h0, 1'b1, 2'd2, 4'd4, 1'b1, 2'd3, 4'd4},
    '{3'd0, 1'b1, 4'hF, 4'h1, Z, Z, Z, 4'h0, 1'b1, 2'd1, 4'd4, 1'b1, 2'd2, 4'd4},
    '{3'd1, 1'b0, 4'hF, 4'h0, {6'd5, 6'd1, 6'd3, 6'd1}, Z, Z, 4'h0,
      1'b1, 2'd0, 4'd8, 1'b0, 2'd0, 4'd0},
    '{3'd2, 1'b1, 4'hF, 4'h0, Z, {6'd0, 6'd4, 6'd2, 6'd7}, Z, 4'h0,
      1'b1, 2'd3, 4'd4, 1'b1, 2'd1, 4'd4},
    '{3'd3, 1'b1, 4'b1011, 4'h0, Z, Z, {6'd20, 6'd9, 6'd9, 6'd30}, 4'h0,
      1'b1, 2'd1, 4'd4, 1'b1, 2'd3, 4'd4},
    '{3'd4, 1'b1, 4'hF, 4'h0, Z, Z, Z, 4'b0101, 1'b1, 2'd1, 4'd4, 1'b1, 2'd3, 4'd4},
    '{3'd4, 1'b0, 4'hF, 4'h0, Z, Z, Z, 4'hF, 1'b1, 2'd0, 4'd8, 1'b0, 2'd0, 4'd0},
    '{3'd3, 1'b1, 4'b0100, 4'h0, Z, Z, Z, 4'h0, 1'b1, 2'd2, 4'd4, 1'b0, 2'd0, 4'd0},
    '{3'd0, 1'b1, 4'hF, 4'hF, Z, Z, Z, 4'h0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0, 4'd0},
    '{3'd0, 1'b0, 4'hF, 4'h0, Z, Z, Z, 4'h0, 1'b1, 2'd3, 4'd8, 1'b0, 2'd0, 4'd0},
    '{3'd1, 1'b1, 4'hF, 4'h0, {6'd2, 6'd2, 6'd2, 6'd2}, Z, Z, 4'h0,
      1'b1, 2'd0, 4'd4, 1'b1, 2'd1, 4'd4},
    '{3'd3, 1'b0, 4'hF, 4'h0, Z, Z, {6'd62, 6'd63, 6'd63, 6'd63}, 4'h0,
      1'b1, 2'd3, 4'd8, 1'b0, 2'd0, 4'd0},
    '{3'd7, 1'b0, 4'hF, 4'h0, Z, Z, {6'd0, 6'd63, 6'd63, 6'd63}, 4'h0,
      1'b1, 2'd0, 4'd8, 1'b0, 2'd0, 4'd0}
  };

  // Requirement exercised by each vector: rotation R5/R3/R4, stall R2,
  // branch R6, miss R7, occupancy R8, queue head R9, tie and pointer R10.
  string tags [NV] = '{"R5 R3", "R5 R10", "R5 R4", "R2 R4", "R6 R10",
                       "R7 R4", "R8 R2", "R9 R4", "R9 R10", "R4 R2",
                       "R2 R10", "R10 R5", "R10 R6", "R8 R3", "R5"};

  task automatic drive(input vec_t v);
    policy     = v.pol;
    split      = v.spl;
    thr_active = v.act;
    thr_stall  = v.stl;
    br_cnt     = v.br;
    miss_cnt   = v.ms;
    inst_cnt   = v.ic;
    near_head  = v.hd;
  endtask

  task automatic check(input string tag, input logic v0, input logic [1:0] t0,
                       input logic [3:0] q0, input logic v1, input logic [1:0] t1,
                       input logic [3:0] q1);
    n_chk++;
    if (slot0_vld !== v0 || slot0_tid !== t0 || slot0_quota !== q0 ||
        slot1_vld !== v1 || slot1_tid !== t1 || slot1_quota !== q1) begin
      n_bad++;
      $display("FAIL %s: got v0=%0b t0=%0d q0=%0d v1=%0b t1=%0d q1=%0d, expected v0=%0b t0=%0d q0=%0d v1=%0b t1=%0d q1=%0d",
               tag, slot0_vld, slot0_tid, slot0_quota, slot1_vld, slot1_tid, slot1_quota,
               v0, t0, q0, v1, t1, q1);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive('0);
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", 1'b0, 2'd0, 4'd0, 1'b0, 2'd0, 4'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      #2;
      check(tags[i], VEC[i].ev0, VEC[i].et0, VEC[i].eq0,
            VEC[i].ev1, VEC[i].et1, VEC[i].eq1);
    end

    // R11: new inputs are not visible before the next edge (pointer is 1 here)
    @(negedge clk);
    drive('{3'd0, 1'b0, 4'hF, 4'h0, Z, Z, Z, 4'h0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0, 4'd0});
    #1;
    check("R11 hold before edge", 1'b1, 2'd0, 4'd8, 1'b0, 2'd0, 4'd0);
    @(posedge clk);
    #2;
    check("R11 update after edge", 1'b1, 2'd1, 4'd8, 1'b0, 2'd0, 4'd0);

    // R1: reset in mid-run clears outputs and returns the pointer to thread 0
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1 mid-run reset", 1'b0, 2'd0, 4'd0, 1'b0, 2'd0, 4'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    check("R1 pointer cleared", 1'b1, 2'd0, 4'd8, 1'b0, 2'd0, 4'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule